// File: doc/BRIEF.md
# Eight-Level Prioritised Interrupt Controller

This block gathers eight interrupt request lines and presents a single interrupt output to a processor. It keeps a pending-request register, an in-service register and a mask register. A fixed-priority resolver picks the lowest-numbered pending, unmasked request. That request is presented only when it outranks every level already in service. When the processor acknowledges, the chosen level moves into service and the controller returns an 8-bit vector. The vector is built from a programmed base and the level number.

Software talks to the block through a small register port with select, read, write and one address line. A restart word sets the trigger mode and tells the controller whether an extra word will follow. A base word comes next, then the optional extra word. After that, address-1 writes load the mask. Address-0 writes carry either an end-of-interrupt command or a choice of which register an address-0 read returns. Only one device and only fixed priority are modelled.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `int_o` and `vec_vld` are low and the pending, in-service and mask registers are all zero. The controller waits for a restart word, and the read select points at the pending register.
- R2: A write with `a0`=0 and `wdata[4]`=1 is a restart word. It clears the pending, in-service and mask registers and points the read select at the pending register. It takes `wdata[3]` as the trigger mode (1 = level, 0 = edge) and `wdata[0]` as "extra word follows". The next `a0`=1 write is the base word. One more `a0`=1 write is then consumed only if `wdata[0]` was 1. After that the controller runs.
- R3: The base word supplies bits 7:3 of the vector. The vector is {base, level number}.
- R4: In edge mode, a low-to-high change on a line sets its pending bit one clock later. The bit is cleared when that level is acknowledged. After a restart word, a line that is already high must go low before it can raise a request again.
- R5: In level mode, each pending bit follows its input line with one clock of delay. Acknowledging does not clear it.
- R6: In the running state, an `a0`=1 write loads the mask. A masked line never drives `int_o`. An `a0`=1 read returns the mask.
- R7: Level 0 has the highest priority. A pending, unmasked request is presented only if its number is lower than every in-service level.
- R8: `int_o` is high exactly when the controller is running and a request is presentable, as defined by R7. It is combinational from the registers.
- R9: An `ack` pulse while `int_o` is high sets the winning level's in-service bit. `vec_vld` and `vec_o` then appear for one cycle after that clock edge. An `ack` while `int_o` is low has no effect.
- R10: A running-state write with `a0`=0, `wdata[4]`=0, `wdata[3]`=0 and `wdata[5]`=1 clears the lowest-numbered set in-service bit.
- R11: A running-state write with `a0`=0, `wdata[4]`=0 and `wdata[3]`=1 chooses what an `a0`=0 read returns. If `wdata[0]`=1 the read returns the in-service register; if `wdata[0]`=0 it returns the pending register. `rdata` is zero whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit n is level n |
| sel | input | 1 | Register port select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| a0 | input | 1 | Register address line |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_o | output | 1 | Interrupt to processor |
| vec_o | output | 8 | Vector of the acknowledged level |
| vec_vld | output | 1 | Vector valid, one cycle |

## Verification
A request edge or level change shows in the pending register and on `int_o` one clock after it is sampled. Mask, restart and end-of-interrupt writes affect `int_o` one clock after the write cycle. The vector and `vec_vld` are due one clock after the acknowledge edge. `rdata` is combinational within the read cycle. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output a moment after each falling edge, so every check lands in the cycle in which that result is due.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int DATA_W  = 8;
    localparam int BASE_W  = DATA_W - LVL_W;

    // command word bit positions
    localparam int CB_RESTART = 4;
    localparam int CB_TRIG    = 3;
    localparam int CB_EXTRA   = 0;
    localparam int CB_RSEL    = 3;
    localparam int CB_RSELVAL = 0;
    localparam int CB_EOI     = 5;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BASE  = 2'd1,
        PH_EXTRA = 2'd2,
        PH_RUN   = 2'd3
    } init_phase_e;

    typedef struct packed {
        logic             found;
        logic [LVL_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic restart;
        logic mask_wr;
        logic eoi;
    } cmd_pulse_t;

    function automatic pick_t pick_first(input lvl_vec_t v);
        pick_t r;
        r = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = LVL_W'(i);
            end
        end
        return r;
    endfunction

    function automatic lvl_vec_t onehot_of(input pick_t p);
        lvl_vec_t v;
        v = '0;
        if (p.found) v[p.idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    output cmd_pulse_t        pulses,
    output logic              running,
    output logic              level_mode,
    output logic              read_isr,
    output logic [BASE_W-1:0] vec_base,
    output lvl_vec_t          mask_val
);

    init_phase_e phase_q;
    logic        extra_q;
    logic        wr_en;
    logic        restart_w;
    logic        rsel_w;

    assign wr_en     = sel && wr;
    assign restart_w = wr_en && !a0 && wdata[CB_RESTART];
    assign running   = (phase_q == PH_RUN);
    assign rsel_w    = wr_en && running && !a0 && !wdata[CB_RESTART] && wdata[CB_RSEL];

    always_comb begin
        pulses         = '0;
        pulses.restart = restart_w;
        pulses.mask_wr = wr_en && running && a0;
        pulses.eoi     = wr_en && running && !a0 && !wdata[CB_RESTART]
                         && !wdata[CB_RSEL] && wdata[CB_EOI];
    end

    assign mask_val = lvl_vec_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            extra_q    <= 1'b0;
            level_mode <= 1'b0;
            read_isr   <= 1'b0;
            vec_base   <= '0;
        end else if (restart_w) begin
            phase_q    <= PH_BASE;
            extra_q    <= wdata[CB_EXTRA];
            level_mode <= wdata[CB_TRIG];
            read_isr   <= 1'b0;
        end else begin
            if (wr_en && a0) begin
                case (phase_q)
                    PH_BASE: begin
                        vec_base <= wdata[DATA_W-1:LVL_W];
                        phase_q  <= extra_q ? PH_EXTRA : PH_RUN;
                    end
                    PH_EXTRA: phase_q <= PH_RUN;
                    default: ;
                endcase
            end
            if (rsel_w) read_isr <= wdata[CB_RSELVAL];
        end
    end

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_prio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t irq_in,
    input  logic     level_mode,
    input  logic     restart,
    input  lvl_vec_t clr,
    output lvl_vec_t irr
);

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
        logic prev_q;
        logic req_q;

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                prev_q <= 1'b1;
                req_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (level_mode)
                    req_q <= irq_in[g];
                else
                    req_q <= (req_q && !clr[g]) || (irq_in[g] && !prev_q);
            end
        end

        assign irr[g] = req_q;
    end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_prio_pkg::*;
(
    input  lvl_vec_t irr,
    input  lvl_vec_t imr,
    input  lvl_vec_t isr,
    output logic     present,
    output pick_t    win
);

    pick_t top_srv;

    always_comb begin
        win     = pick_first(irr & ~imr);
        top_srv = pick_first(isr);
        present = win.found && (!top_srv.found || (win.idx < top_srv.idx));
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        irq_in,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic              a0,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ack,
    output logic              int_o,
    output logic [7:0]        vec_o,
    output logic              vec_vld
);

    cmd_pulse_t        pulses;
    logic              running;
    logic              level_mode;
    logic              read_isr;
    logic [BASE_W-1:0] vec_base;
    lvl_vec_t          mask_val;
    lvl_vec_t          irr;
    lvl_vec_t          isr;
    lvl_vec_t          imr;
    lvl_vec_t          ack_set;
    lvl_vec_t          eoi_clr;
    logic              present;
    pick_t             win;
    logic              take;

    irq_cmd_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .wr         (wr),
        .a0         (a0),
        .wdata      (wdata),
        .pulses     (pulses),
        .running    (running),
        .level_mode (level_mode),
        .read_isr   (read_isr),
        .vec_base   (vec_base),
        .mask_val   (mask_val)
    );

    irq_req_latch u_req (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .level_mode (level_mode),
        .restart    (pulses.restart),
        .clr        (ack_set),
        .irr        (irr)
    );

    irq_prio_resolve u_res (
        .irr     (irr),
        .imr     (imr),
        .isr     (isr),
        .present (present),
        .win     (win)
    );

    assign int_o   = running && present;
    assign take    = ack && int_o;
    assign ack_set = take ? onehot_of(win) : '0;
    assign eoi_clr = pulses.eoi ? onehot_of(pick_first(isr)) : '0;

    always_ff @(posedge clk) begin
        if (rst || pulses.restart) begin
            isr <= '0;
            imr <= '0;
        end else begin
            isr <= (isr & ~eoi_clr) | ack_set;
            if (pulses.mask_wr) imr <= mask_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_vld <= 1'b0;
            vec_o   <= '0;
        end else begin
            vec_vld <= take;
            if (take) vec_o <= {vec_base, win.idx};
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && rd) begin
            if (a0)            rdata = imr;
            else if (read_isr) rdata = isr;
            else               rdata = irr;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       wr,
    input logic       a0,
    input logic [7:0] wdata,
    input logic       ack,
    input logic       int_o,
    input logic       vec_vld,
    input logic       running,
    input lvl_vec_t   irr,
    input lvl_vec_t   isr,
    input lvl_vec_t   imr
);

    logic any_wr;
    logic eoi_wr;
    assign any_wr = sel && wr;
    assign eoi_wr = any_wr && running && !a0 && !wdata[4] && !wdata[3] && wdata[5];

    // R9: accepted acknowledge yields a vector next cycle
    assert_vec_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && int_o) |=> vec_vld);

    // R9: no vector without an accepted acknowledge
    assert_no_spurious_vec_R9: assert property (@(posedge clk) disable iff (rst)
        !(ack && int_o) |=> !vec_vld);

    // R9: accepted acknowledge adds exactly one in-service level
    assert_ack_sets_isr_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && int_o && !any_wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R6: interrupt only with some unmasked pending level
    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        int_o |-> ((irr & ~imr) != '0));

    // R8: no interrupt before initialization is complete
    assert_int_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
        !running |-> !int_o);

    // R2: restart word clears in-service and mask
    assert_restart_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (any_wr && !a0 && wdata[4]) |=> (isr == '0 && imr == '0 && irr == '0));

    // R10: end of interrupt removes exactly one in-service level
    assert_eoi_clears_one_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && isr != '0 && !(ack && int_o)) |=> ($countones(isr) == $countones($past(isr)) - 1));

    // R1: reset leaves no interrupt
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!int_o && !vec_vld));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .wr      (wr),
    .a0      (a0),
    .wdata   (wdata),
    .ack     (ack),
    .int_o   (int_o),
    .vec_vld (vec_vld),
    .running (running),
    .irr     (irr),
    .isr     (isr),
    .imr     (imr)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0, a0 = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, vec_o;
    logic       int_o, vec_vld;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sel(sel), .rd(rd), .wr(wr),
        .a0(a0), .wdata(wdata), .rdata(rdata), .ack(ack), .int_o(int_o),
        .vec_o(vec_o), .vec_vld(vec_vld)
    );

    // ---------------- behavioural reference model ----------------
    int         m_phase;   // 0 idle, 1 base, 2 extra, 3 run
    bit         m_extra, m_lvl, m_rsel, m_vv;
    logic [4:0] m_base;
    logic [7:0] m_irr, m_isr, m_imr, m_prev, m_vec;
    logic [7:0] t_isr, t_rise;
    int         t_w, t_s;
    bit         t_take;

    function automatic int first_set(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit m_int();
        int p;
        p = first_set(m_irr & ~m_imr);
        return (m_phase == 3) && (p < 8) && (p < first_set(m_isr));
    endfunction

    function automatic logic [7:0] m_rdata();
        if (!(sel && rd)) return 8'h00;
        if (a0) return m_imr;
        return m_rsel ? m_isr : m_irr;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_extra = 0; m_lvl = 0; m_rsel = 0; m_vv = 0;
            m_base = '0; m_irr = '0; m_isr = '0; m_imr = '0; m_prev = 8'hFF; m_vec = '0;
        end else begin
            t_take = ack && m_int();
            t_w    = first_set(m_irr & ~m_imr);
            t_isr  = m_isr;
            t_rise = irq_in & ~m_prev;
            if (sel && wr && !a0 && !wdata[4] && !wdata[3] && wdata[5] && m_phase == 3) begin
                t_s = first_set(m_isr);
                if (t_s < 8) t_isr[t_s] = 1'b0;
            end
            if (t_take) begin
                t_isr[t_w] = 1'b1;
                m_vec = {m_base, 3'(t_w)};
            end
            m_vv = t_take;
            if (m_lvl) m_irr = irq_in;
            else begin
                if (t_take) m_irr[t_w] = 1'b0;
                m_irr = m_irr | t_rise;
            end
            m_isr  = t_isr;
            m_prev = irq_in;
            if (sel && wr && !a0 && wdata[4]) begin
                m_irr = '0; m_isr = '0; m_imr = '0; m_prev = 8'hFF;
                m_phase = 1; m_lvl = wdata[3]; m_extra = wdata[0]; m_rsel = 0;
            end else if (sel && wr) begin
                if (a0) begin
                    if (m_phase == 1) begin
                        m_base = wdata[7:3];
                        m_phase = m_extra ? 2 : 3;
                    end else if (m_phase == 2) m_phase = 3;
                    else if (m_phase == 3) m_imr = wdata;
                end else if (m_phase == 3 && wdata[3]) m_rsel = wdata[0];
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R8", "int_o", int'(int_o), int'(m_int()));
            check("R9", "vec_vld", int'(vec_vld), int'(m_vv));
            check("R11", "rdata", int'(rdata), int'(m_rdata()));
            if (m_vv) check("R3", "vec_o", int'(vec_o), int'(m_vec));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wreg(input logic addr, input logic [7:0] d);
        @(negedge clk); sel = 1; wr = 1; a0 = addr; wdata = d;
        @(negedge clk); sel = 0; wr = 0; a0 = 0; wdata = '0;
    endtask

    task automatic rreg(input logic addr, output logic [7:0] d);
        @(negedge clk); sel = 1; rd = 1; a0 = addr;
        #2 d = rdata;
        @(negedge clk); sel = 0; rd = 0; a0 = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        #2;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk); #2;
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [7:0] r;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #2;
        check("R1", "int_o after reset", int'(int_o), 0);
        check("R1", "vec_vld after reset", int'(vec_vld), 0);
        rreg(1'b1, r); check("R1", "mask after reset", int'(r), 0);
        rreg(1'b0, r); check("R1", "pending after reset", int'(r), 0);

        // edge mode, extra word follows, base 0x40
        wreg(0, 8'h11); wreg(1, 8'h40);
        set_irq(8'h08);
        check("R2", "no int before extra word", int'(int_o), 0);
        wreg(1, 8'h01); #2;
        check("R4", "edge request presented", int'(int_o), 1);
        pulse_ack();
        check("R9", "vec_vld after ack", int'(vec_vld), 1);
        check("R3", "vector level 3", int'(vec_o), 8'h43);
        check("R4", "int drops once in service", int'(int_o), 0);
        wreg(0, 8'h0B); rreg(0, r); check("R11", "isr readback", int'(r), 8'h08);
        wreg(0, 8'h0A); rreg(0, r); check("R4", "pending cleared by ack", int'(r), 0);

        set_irq(8'h2A);
        check("R7", "level 1 outranks service 3", int'(int_o), 1);
        pulse_ack();
        check("R3", "vector level 1", int'(vec_o), 8'h41);
        check("R7", "level 5 held back", int'(int_o), 0);
        wreg(0, 8'h20); #2;
        check("R10", "eoi leaves 3, 5 still blocked", int'(int_o), 0);
        wreg(0, 8'h20); #2;
        check("R10", "eoi frees level 5", int'(int_o), 1);
        wreg(1, 8'h20); #2;
        check("R6", "mask hides level 5", int'(int_o), 0);
        rreg(1, r); check("R6", "mask readback", int'(r), 8'h20);
        wreg(1, 8'h00); #2;
        check("R6", "unmask shows level 5", int'(int_o), 1);
        pulse_ack();
        check("R3", "vector level 5", int'(vec_o), 8'h45);
        wreg(0, 8'h20);
        pulse_ack();
        check("R9", "ack with int low ignored", int'(vec_vld), 0);

        // restart while lines held high: re-arm
        wreg(0, 8'h11); wreg(1, 8'h60); wreg(1, 8'h01); #2;
        check("R4", "held lines not taken after restart", int'(int_o), 0);
        rreg(0, r); check("R2", "restart selects pending read", int'(r), 0);
        set_irq(8'h00);
        set_irq(8'h04);
        check("R4", "fresh edge after re-arm", int'(int_o), 1);
        pulse_ack();
        check("R3", "vector with new base", int'(vec_o), 8'h62);
        wreg(0, 8'h20);

        // level mode, no extra word, base 0x80
        wreg(0, 8'h18); wreg(1, 8'h80);
        set_irq(8'h10);
        check("R5", "level request", int'(int_o), 1);
        set_irq(8'h00);
        check("R5", "level request withdrawn", int'(int_o), 0);
        set_irq(8'h10);
        pulse_ack();
        check("R3", "vector level 4", int'(vec_o), 8'h84);
        rreg(0, r); check("R5", "pending kept after ack", int'(r), 8'h10);
        wreg(0, 8'h20); #2;
        check("R10", "eoi re-presents held level", int'(int_o), 1);
        set_irq(8'h00);

        // mixed traffic in edge mode
        wreg(0, 8'h10); wreg(1, 8'hA8);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            irq_in = 8'($urandom);
            ack = ($urandom % 3) == 0;
            sel = 0; wr = 0; rd = 0; a0 = 0; wdata = '0;
            case ($urandom % 8)
                0: begin sel = 1; wr = 1; wdata = 8'h20; end
                1: begin sel = 1; wr = 1; a0 = 1; wdata = 8'($urandom) & 8'h55; end
                2: begin sel = 1; wr = 1; wdata = 8'h08 | 8'($urandom % 2); end
                3: begin sel = 1; rd = 1; a0 = 1'($urandom); end
                default: ;
            endcase
        end
        @(negedge clk);
        ack = 0; sel = 0; wr = 0; rd = 0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule